// File: doc/BRIEF.md
# Load Latency Fast-Path Selector

This block sits at the address-generation stage of a two-lane load pipeline. For every load offered on a lane, it decides whether the load may take a speculative short-latency path or must take the normal path. The short path starts the cache index from the raw base value before the address add has finished. That guess is only safe when the final address stays in the base's 4 KiB page. The block forms the full address, checks the page after the add, and reports the latency the load will see: 4 cycles for a good guess, 5 for the normal path, and 10 for a guess that failed and needs a replay.

Only a base produced by an earlier load, with a non-negative displacement, is a candidate for the guess. A base produced by an ALU operation never is. Each result leaves with a one-bit replay tag that the scheduler forwards to the loads that consume it. A consumer whose producer carries a set tag is kept off the short path, whatever its displacement. So a chain that crosses a page on every load alternates between 10 and 5 cycles.

A failed guess raises a one-cycle replay request with the lane number. The request is driven by a two-state arbiter:
- **IDLE**: requests go out for single failures. When both lanes fail together, lane 0 is granted and the transition IDLE→HOLD is taken.
- **HOLD**: lane 1 is granted, followed by the transition HOLD→IDLE.

In the IDLE cycle that precedes HOLD, the block raises `issue_hold`. Any load offered in that cycle is discarded, so a third replay cannot collide with the held one.

Top module: `flp_sel_top`

## Requirements
- R1: A valid load whose producer is a load (`src_is_load`=1), whose producer tag is clear, whose displacement is non-negative and whose sum keeps bits [63:12] of the base reports latency 4 and a clear replay tag.
- R2: A load whose producer is an ALU operation (`src_is_load`=0) reports latency 5, tag clear, no replay.
- R3: A load with a negative displacement (bit 31 set) reports latency 5, tag clear, no replay.
- R4: An otherwise short-path-eligible load whose sum differs from the base in bits [63:12] reports latency 10 with the replay tag set.
- R5: A load whose producer tag is set (`src_replayed`=1) reports latency 5 with tag clear, including at displacement zero.
- R6: Each accepted load produces `res_vld`, `res_lat`, `res_addr` and `res_rtag` one clock after issue, with `res_addr` equal to base plus the sign-extended displacement.
- R7: A single lane failure raises `replay_req` for exactly one cycle, in the cycle its result is presented, with `replay_port` giving the lane index.
- R8: When both lanes fail in the same cycle, lane 0 is requested in that cycle and lane 1 in the next. `issue_hold` is high in the first of these cycles, and loads offered then produce no result.
- R9: The two lanes decide independently: both may take the short path in the same cycle.
- R10: A page cross on a normal-path load (ALU producer or negative displacement) raises no replay and keeps latency 5.
- R11: After reset and for cycles without an accepted load, `res_vld`, `replay_req` and `issue_hold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 2 | Load offered on each lane |
| iss_base | input | 2x64 | Base register value per lane |
| iss_disp | input | 2x32 | Signed displacement per lane |
| src_is_load | input | 2 | Base producer kind: 1 load, 0 ALU |
| src_replayed | input | 2 | Replay tag carried by the base value |
| issue_hold | output | 1 | Loads offered this cycle are discarded |
| res_vld | output | 2 | Result present per lane |
| res_lat | output | 2x4 | Load-to-use latency: 4, 5 or 10 |
| res_addr | output | 2x64 | Computed address |
| res_rtag | output | 2 | Replay tag for the result |
| replay_req | output | 1 | Replay request pulse |
| replay_port | output | 1 | Lane being replayed |

## Verification
Two things can land in the same cycle: page-cross failures on both lanes, and new issue while the arbiter is about to hold. The bench makes both lanes cross a page together. It then offers fresh short-path loads in the very cycle that `issue_hold` is raised. The checks confirm lane 0 is requested first, lane 1 one cycle later, and that the loads offered during the hold never appear as results.

// File: rtl/flp_pkg.sv
package flp_pkg;
    parameter int LANES  = 2;
    parameter int LAT_W  = 4;
    parameter logic [LAT_W-1:0] LAT_SHORT = 4'd4;
    parameter logic [LAT_W-1:0] LAT_NORM  = 4'd5;
    parameter logic [LAT_W-1:0] LAT_MISS  = 4'd10;

    typedef enum logic [1:0] {
        PATH_SHORT = 2'd0,
        PATH_NORM  = 2'd1,
        PATH_MISS  = 2'd2
    } path_e;

    function automatic logic [LAT_W-1:0] path_lat(input path_e p);
        unique case (p)
            PATH_SHORT: return LAT_SHORT;
            PATH_MISS:  return LAT_MISS;
            default:    return LAT_NORM;
        endcase
    endfunction
endpackage

// File: rtl/flp_lane.sv
module flp_lane
    import flp_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 32,
    parameter int PB = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [AW-1:0]    base,
    input  logic [DW-1:0]    disp,
    input  logic             src_is_load,
    input  logic             src_replayed,
    output logic             vld_q,
    output logic [LAT_W-1:0] lat_q,
    output logic [AW-1:0]    addr_q,
    output logic             miss_q
);
    localparam int PAGE_HI = AW - 1;

    logic [AW-1:0] sum;
    logic          eligible;
    logic          crossed;
    path_e         path_d;
    path_e         path_q;

    always_comb begin
        sum      = base + {{(AW-DW){disp[DW-1]}}, disp};
        eligible = src_is_load && !src_replayed && !disp[DW-1];
        crossed  = base[PAGE_HI:PB] != sum[PAGE_HI:PB];
        if (!eligible)    path_d = PATH_NORM;
        else if (crossed) path_d = PATH_MISS;
        else              path_d = PATH_SHORT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            path_q <= PATH_NORM;
            addr_q <= '0;
        end else begin
            vld_q <= accept;
            if (accept) begin
                path_q <= path_d;
                addr_q <= sum;
            end
        end
    end

    always_comb begin
        lat_q  = path_lat(path_q);
        miss_q = vld_q && (path_q == PATH_MISS);
    end

    // R1
    short_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vld_q == 1'b0 && 1'b1) |=> (lat_q != LAT_SHORT) || $past(src_is_load && !src_replayed && !disp[DW-1]));

    // R4
    miss_crossed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (lat_q != LAT_MISS) || ($past(base[PAGE_HI:PB]) != addr_q[PAGE_HI:PB]));

    // R11
    no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !vld_q);
endmodule

// File: rtl/flp_replay_arb.sv
module flp_replay_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] miss,
    output logic       replay_req,
    output logic       replay_port,
    output logic       hold
);
    typedef enum logic {RP_IDLE, RP_HOLD} rp_state_e;

    rp_state_e state_q;
    rp_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        replay_req  = 1'b0;
        replay_port = 1'b0;
        hold        = 1'b0;
        unique case (state_q)
            RP_IDLE: begin
                replay_req  = |miss;
                replay_port = !miss[0];
                hold        = &miss;
                state_d     = (&miss) ? RP_HOLD : RP_IDLE;
            end
            RP_HOLD: begin
                replay_req  = 1'b1;
                replay_port = 1'b1;
                state_d     = RP_IDLE;
            end
        endcase
    end

    // R8
    hold_grants_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RP_HOLD) |-> (replay_req && replay_port));

    // R8
    hold_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RP_HOLD) |=> (state_q == RP_IDLE));

    // R7
    req_has_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_req && state_q == RP_IDLE) |-> miss[replay_port]);
endmodule

// File: rtl/flp_sel_top.sv
module flp_sel_top
    import flp_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 32,
    parameter int PB = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            iss_vld,
    input  logic [LANES-1:0][AW-1:0]    iss_base,
    input  logic [LANES-1:0][DW-1:0]    iss_disp,
    input  logic [LANES-1:0]            src_is_load,
    input  logic [LANES-1:0]            src_replayed,
    output logic                        issue_hold,
    output logic [LANES-1:0]            res_vld,
    output logic [LANES-1:0][LAT_W-1:0] res_lat,
    output logic [LANES-1:0][AW-1:0]    res_addr,
    output logic [LANES-1:0]            res_rtag,
    output logic                        replay_req,
    output logic                        replay_port
);
    logic [LANES-1:0] miss;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        flp_lane #(.AW(AW), .DW(DW), .PB(PB)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .accept      (iss_vld[g] && !issue_hold),
            .base        (iss_base[g]),
            .disp        (iss_disp[g]),
            .src_is_load (src_is_load[g]),
            .src_replayed(src_replayed[g]),
            .vld_q       (res_vld[g]),
            .lat_q       (res_lat[g]),
            .addr_q      (res_addr[g]),
            .miss_q      (miss[g])
        );
    end

    assign res_rtag = miss;

    flp_replay_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss       (miss),
        .replay_req (replay_req),
        .replay_port(replay_port),
        .hold       (issue_hold)
    );

    // R8
    hold_drops_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hold |=> (res_vld == '0));
endmodule

// File: tb/sim_flp_sel_top.sv
module sim_flp_sel_top;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       iss_vld = '0;
    logic [1:0][63:0] iss_base = '0;
    logic [1:0][31:0] iss_disp = '0;
    logic [1:0]       src_is_load = '0;
    logic [1:0]       src_replayed = '0;
    logic             issue_hold;
    logic [1:0]       res_vld;
    logic [1:0][3:0]  res_lat;
    logic [1:0][63:0] res_addr;
    logic [1:0]       res_rtag;
    logic             replay_req;
    logic             replay_port;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flp_sel_top u0 (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int p, input logic [63:0] b, input logic [31:0] d,
                       input logic ld, input logic rp);
        iss_vld[p]      = 1'b1;
        iss_base[p]     = b;
        iss_disp[p]     = d;
        src_is_load[p]  = ld;
        src_replayed[p] = rp;
    endtask

    task automatic idle_in();
        iss_vld = '0; src_is_load = '0; src_replayed = '0;
    endtask

    task automatic lane_res(input string req, input int p, input logic [3:0] lat,
                            input logic [63:0] addr, input logic tag);
        chk(req, "res_vld", 64'(res_vld[p]), 64'd1);
        chk(req, "res_lat", 64'(res_lat[p]), 64'(lat));
        chk(req, "res_addr", res_addr[p], addr);
        chk(req, "res_rtag", 64'(res_rtag[p]), 64'(tag));
    endtask

    // one load on lane p, checked one clock later
    task automatic one(input string req, input int p, input logic [63:0] b, input logic [31:0] d,
                       input logic ld, input logic rp, input logic [3:0] lat,
                       input logic [63:0] addr, input logic tag);
        @(negedge clk); idle_in(); put(p, b, d, ld, rp);
        @(negedge clk);
        lane_res(req, p, lat, addr, tag);
        chk(req, "replay_req", 64'(replay_req), 64'(tag));
        if (tag) chk(req, "replay_port", 64'(replay_port), 64'(p));
        idle_in();
    endtask

    task automatic t_reset();
        chk("R11", "res_vld", 64'(res_vld), 64'd0);
        chk("R11", "replay_req", 64'(replay_req), 64'd0);
        chk("R11", "issue_hold", 64'(issue_hold), 64'd0);
    endtask

    task automatic t_basic();
        one("R1", 0, 64'h1000, 32'd8, 1, 0, 4'd4, 64'h1008, 0);
        one("R1", 1, 64'h3000, 32'hFFF, 1, 0, 4'd4, 64'h3FFF, 0);
        one("R2", 0, 64'h1000, 32'd8, 0, 0, 4'd5, 64'h1008, 0);
        one("R3", 1, 64'h2010, 32'hFFFF_FFF0, 1, 0, 4'd5, 64'h2000, 0);
        one("R4", 0, 64'h1FF8, 32'h10, 1, 0, 4'd10, 64'h2008, 1);
        one("R7", 1, 64'h5FFF, 32'd1, 1, 0, 4'd10, 64'h6000, 1);
        one("R5", 0, 64'h7000, 32'd0, 1, 1, 4'd5, 64'h7000, 0);
        one("R10", 0, 64'h1FF8, 32'h10, 0, 0, 4'd5, 64'h2008, 0);
        one("R10", 1, 64'h2000, 32'hFFFF_FFF8, 1, 0, 4'd5, 64'h1FF8, 0);
        one("R6", 0, 64'hFFFF_0000_0000_0100, 32'h8000_0000, 0, 0, 4'd5, 64'hFFFE_FFFF_8000_0100, 0);
    endtask

    task automatic t_chain();
        one("R5", 0, 64'h0FF0, 32'h20, 1, 0, 4'd10, 64'h1010, 1);
        one("R5", 0, 64'h1FF0, 32'h20, 1, 1, 4'd5, 64'h2010, 0);
        one("R5", 0, 64'h2FF0, 32'h20, 1, 0, 4'd10, 64'h3010, 1);
    endtask

    task automatic t_dual_short();
        @(negedge clk); idle_in();
        put(0, 64'h4000, 32'h10, 1, 0); put(1, 64'h8000, 32'h20, 1, 0);
        @(negedge clk);
        lane_res("R9", 0, 4'd4, 64'h4010, 0);
        lane_res("R9", 1, 4'd4, 64'h8020, 0);
        chk("R9", "replay_req", 64'(replay_req), 64'd0);
        idle_in();
    endtask

    task automatic t_dual_miss();
        @(negedge clk); idle_in();
        put(0, 64'h0FFF, 32'd1, 1, 0); put(1, 64'h1FFF, 32'd2, 1, 0);
        @(negedge clk);
        lane_res("R8", 0, 4'd10, 64'h1000, 1);
        lane_res("R8", 1, 4'd10, 64'h2001, 1);
        chk("R8", "replay_req c1", 64'(replay_req), 64'd1);
        chk("R8", "replay_port c1", 64'(replay_port), 64'd0);
        chk("R8", "issue_hold c1", 64'(issue_hold), 64'd1);
        idle_in();
        put(0, 64'h4000, 32'd4, 1, 0); put(1, 64'h4000, 32'd4, 1, 0);
        @(negedge clk);
        chk("R8", "replay_req c2", 64'(replay_req), 64'd1);
        chk("R8", "replay_port c2", 64'(replay_port), 64'd1);
        chk("R8", "dropped res_vld", 64'(res_vld), 64'd0);
        chk("R8", "issue_hold c2", 64'(issue_hold), 64'd0);
        idle_in();
        @(negedge clk);
        chk("R7", "replay_req after", 64'(replay_req), 64'd0);
        chk("R11", "res_vld idle", 64'(res_vld), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_chain();
        t_dual_short();
        t_dual_miss();
        t_dual_short();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule